// File: doc/BRIEF.md
# Secondary Processor Control Register

This block is a write-only command register on the main processor's bus. A main processor uses it to keep a secondary processor in reset, to let it run, or to interrupt it. Every write presents a 16-bit word. The word is compared in full against a small set of command codes. Several different codes share the same action.

The reset output is sticky. It changes only when a command moves it to the other state, so repeated commands do not toggle it. The interrupt request stays high until the secondary processor returns an acknowledge. A run command also sends the main processor a one-cycle wait hint, which tells it to idle until its next interrupt. A word that matches no code has no effect.

Two state machines hold the block's state. The reset machine has the states HELD and RUNNING, with the transitions HELD to RUNNING on a run command and RUNNING to HELD on a hold command. The interrupt machine has the states IDLE and PENDING, with the transitions IDLE to PENDING on an interrupt command and PENDING to IDLE on an acknowledge when no interrupt command arrives in the same cycle. All outputs are registered and change one clock after the write or acknowledge that causes them.

Top module: `sub_ctl_reg`

## Requirements
- R1: After reset, sub_reset is 1, sub_irq is 0 and main_wait is 0.
- R2: A write of 0x0001, 0x000D or 0x000F (a hold command) sets sub_reset to 1 from the next cycle. A hold write while already held leaves it at 1.
- R3: A write of 0x0000 (a run command) clears sub_reset to 0 from the next cycle. A run write while already running leaves it at 0.
- R4: Each 0x0000 write drives main_wait high for exactly the next cycle, whatever the reset state. No other stimulus raises main_wait.
- R5: A write of 0x000C or 0x0080 (an interrupt command) sets sub_irq to 1 from the next cycle. sub_irq stays 1 until an acknowledge is seen.
- R6: While sub_irq is 1, sub_ack high with no interrupt command in the same cycle clears sub_irq in the next cycle.
- R7: An interrupt command in the same cycle as sub_ack keeps sub_irq at 1.
- R8: A write of any other 16-bit value leaves sub_reset and sub_irq unchanged and gives no main_wait pulse. This includes a value whose low byte is a command code but whose upper byte is nonzero, such as 0x0100. A cycle with wr_en low has the same null effect, and sub_ack while sub_irq is 0 has no effect.
- R9: The two state machines are independent. Hold and run writes do not change sub_irq, and interrupt writes do not change sub_reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe for the register |
| wr_data | input | 16 | Written command word |
| sub_ack | input | 1 | Interrupt acknowledge from the secondary processor |
| sub_reset | output | 1 | Reset line to the secondary processor, active high |
| sub_irq | output | 1 | Held interrupt request to the secondary processor |
| main_wait | output | 1 | One-cycle hint that the main processor should wait for its next interrupt |

## Verification
On every cycle the assertions check the one-cycle effect of each command class on the ports. They cover hold and run reaching the reset line, the single-cycle wait pulse, interrupt set, clear on acknowledge and priority of a new request, and that unrecognised words and interrupt writes leave the reset line stable. Only the bench scenarios show the reset values and long runs of repeated hold or run writes, where the line must not glitch. The bench scenarios also cover aliased codes with a nonzero upper byte and the interleaving of all command classes under random acknowledges.

// File: rtl/sub_ctl_pkg.sv
package sub_ctl_pkg;

    localparam int CMD_W = 16;

    localparam logic [CMD_W-1:0] CODE_RUN    = 16'h0000;
    localparam logic [CMD_W-1:0] CODE_HOLD_A = 16'h0001;
    localparam logic [CMD_W-1:0] CODE_HOLD_B = 16'h000D;
    localparam logic [CMD_W-1:0] CODE_HOLD_C = 16'h000F;
    localparam logic [CMD_W-1:0] CODE_IRQ_A  = 16'h000C;
    localparam logic [CMD_W-1:0] CODE_IRQ_B  = 16'h0080;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_HOLD = 2'd1,
        CMD_RUN  = 2'd2,
        CMD_IRQ  = 2'd3
    } cmd_e;

    typedef enum logic {
        RS_HELD    = 1'b0,
        RS_RUNNING = 1'b1
    } rst_state_e;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

    function automatic cmd_e classify(input logic en, input logic [CMD_W-1:0] word);
        cmd_e c;
        c = CMD_NONE;
        if (en) begin
            case (word)
                CODE_RUN:                              c = CMD_RUN;
                CODE_HOLD_A, CODE_HOLD_B, CODE_HOLD_C: c = CMD_HOLD;
                CODE_IRQ_A, CODE_IRQ_B:                c = CMD_IRQ;
                default:                               c = CMD_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sub_ctl_decode.sv
module sub_ctl_decode
    import sub_ctl_pkg::*;
#(
    parameter int DATA_W = CMD_W
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_e              cmd
);
    // Full-width compare: upper bits must be zero for a code to match.
    localparam int PAD_W = (DATA_W > CMD_W) ? DATA_W - CMD_W : 1;

    logic [CMD_W-1:0] low_word;
    logic             upper_clear;

    generate
        if (DATA_W > CMD_W) begin : g_wide
            logic [PAD_W-1:0] upper_bits;
            assign upper_bits  = wr_data[DATA_W-1:CMD_W];
            assign low_word    = wr_data[CMD_W-1:0];
            assign upper_clear = (upper_bits == '0);
        end else begin : g_exact
            assign low_word    = CMD_W'(wr_data);
            assign upper_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        cmd = classify(wr_en && upper_clear, low_word);
    end

endmodule

// File: rtl/sub_ctl_rst_fsm.sv
module sub_ctl_rst_fsm
    import sub_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    output logic sub_reset,
    output logic main_wait
);
    rst_state_e state_q, state_d;
    logic       wait_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_HELD:    if (cmd == CMD_RUN)  state_d = RS_RUNNING;
            RS_RUNNING: if (cmd == CMD_HOLD) state_d = RS_HELD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_HELD;
            wait_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wait_q  <= (cmd == CMD_RUN);
        end
    end

    always_comb begin
        sub_reset = 1'b1;
        unique case (state_q)
            RS_HELD:    sub_reset = 1'b1;
            RS_RUNNING: sub_reset = 1'b0;
        endcase
        main_wait = wait_q;
    end

endmodule

// File: rtl/sub_ctl_irq_fsm.sv
module sub_ctl_irq_fsm
    import sub_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic ack,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (cmd == CMD_IRQ) state_d = IRQ_PENDING;
            IRQ_PENDING: if (cmd != CMD_IRQ && ack) state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            IRQ_IDLE:    irq = 1'b0;
            IRQ_PENDING: irq = 1'b1;
        endcase
    end

endmodule

// File: rtl/sub_ctl_reg.sv
module sub_ctl_reg
    import sub_ctl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sub_ack,
    output logic              sub_reset,
    output logic              sub_irq,
    output logic              main_wait
);
    cmd_e cmd;

    sub_ctl_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    sub_ctl_rst_fsm u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .sub_reset (sub_reset),
        .main_wait (main_wait)
    );

    sub_ctl_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .ack   (sub_ack),
        .irq   (sub_irq)
    );

endmodule

// File: rtl/sub_ctl_chk.sv
module sub_ctl_chk
    import sub_ctl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              sub_ack,
    input logic              sub_reset,
    input logic              sub_irq,
    input logic              main_wait
);
    logic is_run, is_hold, is_irq, is_other;
    assign is_run   = wr_en && (wr_data == DATA_W'(CODE_RUN));
    assign is_hold  = wr_en && (wr_data == DATA_W'(CODE_HOLD_A) ||
                                wr_data == DATA_W'(CODE_HOLD_B) ||
                                wr_data == DATA_W'(CODE_HOLD_C));
    assign is_irq   = wr_en && (wr_data == DATA_W'(CODE_IRQ_A) ||
                                wr_data == DATA_W'(CODE_IRQ_B));
    assign is_other = !is_run && !is_hold && !is_irq;

    a_r2_hold_sets: assert property (@(posedge clk) disable iff (!rst_n)
        is_hold |=> sub_reset);
    a_r3_run_clears: assert property (@(posedge clk) disable iff (!rst_n)
        is_run |=> !sub_reset);
    a_r4_wait_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        is_run |=> main_wait);
    a_r4_no_stray_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !is_run |=> !main_wait);
    a_r5_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        is_irq |=> sub_irq);
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_irq && sub_ack && !is_irq) |=> !sub_irq);
    a_r5_held_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_irq && !sub_ack) |=> sub_irq);
    a_r8_other_reset_stable: assert property (@(posedge clk) disable iff (!rst_n)
        is_other |=> $stable(sub_reset));
    a_r8_other_irq_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (is_other && !sub_ack) |=> $stable(sub_irq));
    a_r9_irq_write_keeps_reset: assert property (@(posedge clk) disable iff (!rst_n)
        is_irq |=> $stable(sub_reset));

endmodule

bind sub_ctl_reg sub_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sub_ack   (sub_ack),
    .sub_reset (sub_reset),
    .sub_irq   (sub_irq),
    .main_wait (main_wait)
);

// File: tb/tb_sub_ctl_reg.sv
module tb_sub_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        sub_ack = 1'b0;
    logic        sub_reset, sub_irq, main_wait;

    int checks = 0;
    int errors = 0;
    logic exp_rst = 1'b1, exp_irq = 1'b0, exp_wait = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sub_ctl_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sub_ack(sub_ack), .sub_reset(sub_reset), .sub_irq(sub_irq),
        .main_wait(main_wait)
    );

    // Expected-value model built from the requirements.
    function automatic logic next_rst(logic cur, logic en, logic [15:0] d);
        if (en && d == 16'h0000) return 1'b0;                       // R3
        if (en && (d == 16'h0001 || d == 16'h000D || d == 16'h000F)) // R2
            return 1'b1;
        return cur;                                                  // R8, R9
    endfunction

    function automatic logic next_irq(logic cur, logic en, logic [15:0] d, logic ack);
        if (en && (d == 16'h000C || d == 16'h0080)) return 1'b1;    // R5, R7
        if (cur && ack) return 1'b0;                                 // R6
        return cur;                                                  // R8
    endfunction

    function automatic logic next_wait(logic en, logic [15:0] d);
        return en && d == 16'h0000;                                  // R4
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        check({tag, "/R2R3"}, sub_reset, exp_rst, "sub_reset");
        check({tag, "/R5R6"}, sub_irq, exp_irq, "sub_irq");
        check({tag, "/R4"}, main_wait, exp_wait, "main_wait");
    endtask

    // Drive one cycle at the falling edge, check the result one edge later.
    task automatic step(string tag, logic en, logic [15:0] d, logic ack);
        wr_en = en; wr_data = d; sub_ack = ack;
        exp_rst  = next_rst(exp_rst, en, d);
        exp_irq  = next_irq(exp_irq, en, d, ack);
        exp_wait = next_wait(en, d);
        @(negedge clk);
        compare_all(tag);
    endtask

    function automatic logic [15:0] pick_word();
        case ($urandom_range(0, 9))
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h000D;
            3: return 16'h000F;
            4: return 16'h000C;
            5: return 16'h0080;
            6: return 16'h0100 | 16'($urandom_range(0, 15));
            default: return 16'($urandom());
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state before any write
        check("R1", sub_reset, 1'b1, "sub_reset");
        check("R1", sub_irq, 1'b0, "sub_irq");
        check("R1", main_wait, 1'b0, "main_wait");

        step("R8_idle", 1'b0, 16'h0000, 1'b1);   // strobe low, ack while idle
        step("R3_run", 1'b1, 16'h0000, 1'b0);
        step("R3_run_again", 1'b1, 16'h0000, 1'b0);
        step("R4_gap", 1'b0, 16'h0000, 1'b0);
        step("R2_hold_D", 1'b1, 16'h000D, 1'b0);
        step("R2_hold_F_again", 1'b1, 16'h000F, 1'b0);
        step("R8_upper_byte", 1'b1, 16'h0100, 1'b0);
        step("R3_run2", 1'b1, 16'h0000, 1'b0);
        step("R8_alias_upper", 1'b1, 16'h0101, 1'b0);
        step("R5_irq_C", 1'b1, 16'h000C, 1'b0);
        step("R9_hold_keeps_irq", 1'b1, 16'h0001, 1'b0);
        step("R5_held", 1'b0, 16'h0000, 1'b0);
        step("R7_req_with_ack", 1'b1, 16'h0080, 1'b1);
        step("R8_other_noack", 1'b1, 16'h1234, 1'b0);
        step("R6_ack", 1'b0, 16'h0000, 1'b1);
        step("R8_ack_idle", 1'b0, 16'h0000, 1'b1);

        for (int i = 0; i < 3000; i++) begin
            logic en;
            logic ack;
            en  = ($urandom_range(0, 3) != 0);
            ack = ($urandom_range(0, 2) == 0);
            step("rand", en, pick_word(), ack);
        end

        // Reset again mid-run: R1
        wr_en = 1'b1; wr_data = 16'h000C; sub_ack = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_rst = 1'b1; exp_irq = 1'b0; exp_wait = 1'b0;
        @(negedge clk);
        compare_all("R1_rereset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule